// File: doc/BRIEF.md
# Sequential Bit-Clearing Population Sweep

This unit fills a small result memory with the number of ones in every integer from zero up to a bound. The caller gives the bound on `sweep_bound`, pulses `start_i` while the unit is idle, and then watches a memory write port. Index `i` is written to slot `i` in rising order, and the slot holds the ones count of `i`.

Each count comes from a working register that is loaded with the index zero-extended to `DATA_W` bits. On every clock the unit replaces the register with its value ANDed with itself minus one. That step drops the lowest one bit, and a counter goes up by one. When the register reaches zero the count is complete and is written out. A count therefore costs one cycle per set bit instead of a parallel adder tree. After the write for the bound, a one-cycle `done_o` pulse is given and the unit goes back to idle.

Top module: `bitsweep_popcnt`

## Requirements
- R1: While reset is high, and in every cycle after reset until a start is accepted, `wr_en_o` and `done_o` are 0.
- R2: `start_i` is accepted only while idle. A start raised during a sweep does not restart it: the index sequence and the number of writes stay the same.
- R3: The bound is captured when a start is accepted. Changes on `sweep_bound` during a sweep do not change the number of writes or their contents.
- R4: One sweep gives exactly bound+1 write strobes, each lasting one cycle. `wr_addr_o` takes the values 0, 1, ..., bound in that order.
- R5: The value on `wr_data_o` is the number of ones in `wr_addr_o`, zero-extended to `DATA_W` bits, with every bit above the count width equal to 0.
- R6: The first write strobe is seen in the third cycle after the edge that accepts the start. The strobe for index i>0 comes popcount(i)+4 cycles after the strobe for index i-1.
- R7: `done_o` is high for exactly one cycle, two cycles after the strobe for the bound. No strobe follows it before the next start.
- R8: A bound of 0 gives a single write of 0 at address 0.
- R9: The all-ones index 2^IDX_W-1 gives a count of IDX_W, and a sweep to that bound ends without wrapping the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a sweep; used only when idle |
| sweep_bound | input | IDX_W | Last index to count, captured at start |
| done_o | output | 1 | One-cycle pulse after the final write |
| wr_en_o | output | 1 | Result memory write strobe |
| wr_addr_o | output | IDX_W | Result memory slot (equals the index) |
| wr_data_o | output | DATA_W | Ones count of the index, zero-extended |

## Verification
The bench goes after the zero index, whose count must take no clearing step. A design that decrements or stepped once would write 1 or mistime the first strobe. The all-ones index at the top of the range must give IDX_W and must stop the sweep. An index that wraps would run through the memory again and never raise done. Start pulses and bound changes are injected in the middle of a sweep: a design that samples either one late would restart or write a different number of slots. The gap between strobes is checked cycle by cycle against popcount+4, which exposes any extra or skipped clearing step.

// File: rtl/bitsweep_pkg.sv
package bitsweep_pkg;

    parameter int unsigned DFLT_DATA_W = 32;
    parameter int unsigned DFLT_IDX_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_CLEAR = 3'd2,
        ST_WRITE = 3'd3,
        ST_NEXT  = 3'd4
    } sweep_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } clr_cmd_t;

    function automatic int unsigned cnt_width(input int unsigned data_w);
        return $clog2(data_w + 1);
    endfunction

endpackage

// File: rtl/bitsweep_clr_unit.sv
module bitsweep_clr_unit
    import bitsweep_pkg::*;
#(
    parameter int unsigned DATA_W = DFLT_DATA_W,
    parameter int unsigned IDX_W  = DFLT_IDX_W,
    localparam int unsigned CNT_W = cnt_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  clr_cmd_t          cmd,
    input  logic [IDX_W-1:0]  seed_idx,
    output logic [DATA_W-1:0] work_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              work_zero
);

    logic [DATA_W-1:0] work_q;
    logic [CNT_W-1:0]  cnt_q;

    assign work_zero = (work_q == '0);
    assign work_o    = work_q;
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            cnt_q  <= '0;
        end else if (cmd.load) begin
            work_q <= DATA_W'(seed_idx);
            cnt_q  <= '0;
        end else if (cmd.step && !work_zero) begin
            work_q <= work_q & (work_q - 1'b1);
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // one clearing step removes exactly one set bit (R6)
    p_step_drops_one_bit_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && !cmd.load && !work_zero) |=>
            ($countones(work_q) + 1 == $countones($past(work_q))))
        else $error("clearing step did not drop exactly one bit");

    // an empty register freezes the count (R5)
    p_zero_freezes_count_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.step && !cmd.load && work_zero) |=> $stable(cnt_q))
        else $error("count moved on a zero working value");

endmodule

// File: rtl/bitsweep_ctrl.sv
module bitsweep_ctrl
    import bitsweep_pkg::*;
#(
    parameter int unsigned IDX_W = DFLT_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [IDX_W-1:0] bound_i,
    input  logic             work_zero,
    output clr_cmd_t         cmd,
    output logic [IDX_W-1:0] idx_o,
    output logic             wr_en_o,
    output logic             done_o,
    output sweep_state_e     state_o
);

    sweep_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] bound_q;
    logic             done_q;
    logic             at_last;

    assign at_last = (idx_q == bound_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_CLEAR;
            ST_CLEAR: if (work_zero) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_NEXT;
            ST_NEXT:  state_d = at_last ? ST_IDLE : ST_LOAD;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            bound_q <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_NEXT) && at_last;
            if (state_q == ST_IDLE && start_i) begin
                bound_q <= bound_i;
                idx_q   <= '0;
            end else if (state_q == ST_NEXT && !at_last) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign cmd.load = (state_q == ST_LOAD);
    assign cmd.step = (state_q == ST_CLEAR);
    assign idx_o    = idx_q;
    assign wr_en_o  = (state_q == ST_WRITE);
    assign done_o   = done_q;
    assign state_o  = state_q;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !wr_en_o)
        else $error("write strobe while idle");

    p_bound_held_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(bound_q))
        else $error("captured bound changed during a sweep");

    p_addr_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (idx_q <= bound_q))
        else $error("write beyond the bound");

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o)
        else $error("write strobe longer than one cycle");

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    p_done_follows_last_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(wr_en_o, 2) && $past(idx_q, 2) == bound_q))
        else $error("done without a final write two cycles earlier");

endmodule

// File: rtl/bitsweep_popcnt.sv
module bitsweep_popcnt
    import bitsweep_pkg::*;
#(
    parameter int unsigned DATA_W = DFLT_DATA_W,
    parameter int unsigned IDX_W  = DFLT_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  sweep_bound,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int unsigned CNT_W = cnt_width(DATA_W);

    clr_cmd_t          cmd;
    logic              work_zero;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] work;
    logic [CNT_W-1:0]  cnt;
    sweep_state_e      state;

    bitsweep_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .bound_i   (sweep_bound),
        .work_zero (work_zero),
        .cmd       (cmd),
        .idx_o     (idx),
        .wr_en_o   (wr_en_o),
        .done_o    (done_o),
        .state_o   (state)
    );

    bitsweep_clr_unit #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_clr (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .seed_idx  (idx),
        .work_o    (work),
        .cnt_o     (cnt),
        .work_zero (work_zero)
    );

    assign wr_addr_o = idx;
    assign wr_data_o = DATA_W'(cnt);

    // steps taken plus bits left always equal the ones of the index (R5)
    p_count_tracks_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |-> (int'(cnt) + $countones(work) == $countones(idx)))
        else $error("count plus remaining bits differs from index ones");

    p_written_value_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_data_o == DATA_W'($countones(wr_addr_o))))
        else $error("written count is not the ones of the address");

endmodule

// File: tb/bitsweep_popcnt_tb.sv
module bitsweep_popcnt_tb;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned IDX_W  = 8;
    localparam int unsigned TOP_IDX = (1 << IDX_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [IDX_W-1:0]  sweep_bound = '0;
    logic              done_o;
    logic              wr_en_o;
    logic [IDX_W-1:0]  wr_addr_o;
    logic [DATA_W-1:0] wr_data_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bitsweep_popcnt #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .sweep_bound (sweep_bound),
        .done_o      (done_o),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );

    function automatic int ref_ones(input int unsigned v);
        int s = 0;
        for (int b = 0; b < 32; b++) s += int'((v >> b) & 1);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_sweep(input int unsigned bound, input bit disturb);
        int k = 1;
        int last_w = 0;
        int unsigned nxt = 0;
        bit seen_done = 0;
        string rq;
        @(negedge clk);
        sweep_bound = IDX_W'(bound);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!seen_done) begin
            if (disturb && k == 5) begin
                start_i = 1'b1;
                sweep_bound = IDX_W'(bound ^ 32'h5A);
            end
            if (disturb && k == 9) start_i = 1'b0;
            if (wr_en_o) begin
                rq = disturb ? "R3" : (nxt == TOP_IDX) ? "R9" : (bound == 0) ? "R8" : "R4";
                chk(nxt <= bound, disturb ? "R2" : rq, "write past bound", nxt, bound);
                chk(wr_addr_o == IDX_W'(nxt), rq, "write address", wr_addr_o, nxt);
                rq = (nxt == TOP_IDX) ? "R9" : (nxt == 0) ? "R8" : "R5";
                chk(wr_data_o == DATA_W'(ref_ones(nxt)), rq, "write data",
                    wr_data_o, ref_ones(nxt));
                if (nxt == 0)
                    chk(k == 3, "R6", "first strobe cycle", k, 3);
                else
                    chk(k - last_w == ref_ones(nxt) + 4, "R6", "strobe gap",
                        k - last_w, ref_ones(nxt) + 4);
                last_w = k;
                nxt++;
            end
            if (done_o) begin
                seen_done = 1;
                chk(k == last_w + 2, "R7", "done timing", k, last_w + 2);
                chk(nxt == bound + 1, disturb ? "R3" : "R4", "write count", nxt, bound + 1);
            end
            if (!seen_done) begin
                @(negedge clk);
                k++;
                if (k > 20000) begin
                    chk(0, "R7", "sweep never finished", k, 20000);
                    seen_done = 1;
                end
            end
        end
        sweep_bound = '0;
        @(negedge clk);
        chk(!done_o, "R7", "done width", done_o, 0);
        chk(!wr_en_o, "R7", "strobe after done", wr_en_o, 0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        chk(0, "R7", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) begin
            @(negedge clk);
            chk(!wr_en_o && !done_o, "R1", "outputs in reset", {wr_en_o, done_o}, 0);
        end
        rst = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(!wr_en_o && !done_o, "R1", "idle outputs", {wr_en_o, done_o}, 0);
        end
        run_sweep(0, 0);
        run_sweep(1, 0);
        run_sweep(7, 0);
        run_sweep(40, 1);
        run_sweep(TOP_IDX, 0);
        for (int t = 0; t < 6; t++) begin
            int unsigned b = $urandom % (TOP_IDX + 1);
            run_sweep(b, (b >= 12) && (t % 2 == 0));
        end
        repeat (5) begin
            @(negedge clk);
            chk(!wr_en_o && !done_o, "R2", "quiet without start", {wr_en_o, done_o}, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule